// File: doc/BRIEF.md
# Internal Data RAM for an 8-bit Core

This block is the 256-byte scratch memory that sits beside an 8-bit controller core. Each clock cycle the core issues one operation on a 4-bit opcode. The operation can be a byte access by direct address, a byte access by pointer (indirect), a working-register access chosen by bank and index, a single-bit access, or a stack push or pop. Read results are registered and appear on the cycle after the operation. Writes land at the same clock edge.

The lower 128 bytes can be reached both directly and through a pointer. The upper 128 bytes can be reached only through a pointer. When a direct access or a bit access points at 0x80 or above, the RAM is not touched. Instead the block raises a select toward the special-function-register logic outside it and hands over the address.

Bytes 0x20 to 0x2F double as a 128-bit field of individually addressed flags. The lowest 32 bytes hold four banks of eight working registers. The stack grows upward through the pointer path, driven by an internal 8-bit stack pointer.

Top module: `idata_ram`

## Requirements
- R1: Indirect byte reads and writes reach every address 0x00 to 0xFF. A read result appears on `rdata` at the clock edge that ends the cycle of the read operation.
- R2: A direct byte access to an address below 0x80 reaches the same byte as an indirect access to that address.
- R3: A direct access to an address of 0x80 or above leaves the RAM unchanged. In the same cycle it drives `sfr_sel` high, `sfr_bit` low and `sfr_addr` equal to `addr`. A direct read there loads 0x00 into `rdata`.
- R4: A register access uses `bank_sel` as bank b and `addr[2:0]` as index n, and reaches byte b*8 + n.
- R5: A bit read of bit address a below 0x80 returns bit (a mod 8) of byte 0x20 + a/8 on `rbit`, one cycle later.
- R6: A bit write below 0x80 sets that one bit to `wbit` in a single cycle and leaves the other seven bits of the byte unchanged.
- R7: A bit access with address 0x80 or above drives `sfr_sel` and `sfr_bit` high and `sfr_addr` equal to `addr` in the same cycle. It leaves the RAM unchanged, and a bit read there loads 0 into `rbit`.
- R8: A push first increments `sp` and then writes `wdata` to the new `sp`. A pop loads the byte at `sp` into `rdata` and then decrements `sp`.
- R9: While `rst_n` is low, `sp` is 0x07, and `rdata` and `rbit` are 0.
- R10: The opcodes are 0 idle, 1 direct read, 2 direct write, 3 indirect read, 4 indirect write, 5 register read, 6 register write, 7 bit read, 8 bit write, 9 push, 10 pop. Codes 11 to 15 act as idle: they change no RAM byte, leave `sp` alone, and `rdata` and `rbit` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code (see R10) |
| addr | input | 8 | Direct/indirect byte address, bit address, or register index in bits 2:0 |
| bank_sel | input | 2 | Working-register bank, mirrors the status-word bank bits |
| wdata | input | 8 | Byte to write or push |
| wbit | input | 1 | Value for a bit write |
| rdata | output | 8 | Registered byte read result |
| rbit | output | 1 | Registered bit read result |
| sfr_sel | output | 1 | Access diverted to special-function registers |
| sfr_bit | output | 1 | Diverted access is a bit access |
| sfr_addr | output | 8 | Forwarded address of a diverted access, else 0 |
| sp | output | 8 | Stack pointer |

## Verification
The SFR outputs (`sfr_sel`, `sfr_bit`, `sfr_addr`) are combinational. The bench reads them one time unit after it drives the inputs, within the same cycle. `rdata`, `rbit` and `sp` pass through one register. They are sampled at the falling edge after the rising edge that ends the operation's cycle. A write is confirmed by a read issued in the following cycle, whose result is checked one further edge later. Stimulus changes only at falling edges, so no sample races a rising edge.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BANK_W = 2;
  localparam int REG_W  = 3;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BIT_WIN_BASE = 8'h20;
  localparam logic [ADDR_W-1:0] BIT_WIN_LAST = BIT_WIN_BASE + ADDR_W'((DEPTH / 2) / DATA_W - 1);

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_DIR_RD = 4'd1,
    OP_DIR_WR = 4'd2,
    OP_IND_RD = 4'd3,
    OP_IND_WR = 4'd4,
    OP_REG_RD = 4'd5,
    OP_REG_WR = 4'd6,
    OP_BIT_RD = 4'd7,
    OP_BIT_WR = 4'd8,
    OP_PUSH   = 4'd9,
    OP_POP    = 4'd10
  } ram_op_e;

  // Working register n of bank b sits at b*8 + n.
  function automatic logic [ADDR_W-1:0] reg_byte_addr(input logic [BANK_W-1:0] bank,
                                                      input logic [REG_W-1:0] idx);
    return ADDR_W'({bank, idx});
  endfunction

  // Flag address -> host byte inside the bit window.
  function automatic logic [ADDR_W-1:0] flag_byte_addr(input logic [ADDR_W-1:0] baddr);
    return BIT_WIN_BASE + (baddr >> POS_W);
  endfunction

  function automatic logic [POS_W-1:0] flag_bit_pos(input logic [ADDR_W-1:0] baddr);
    return baddr[POS_W-1:0];
  endfunction

  function automatic logic in_upper_half(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction
endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              bit_mode,
  output logic [POS_W-1:0]  bit_pos,
  output logic              ld_byte,
  output logic              ld_bit,
  output logic              sfr_hit,
  output logic              sfr_bit_hit,
  output logic              sp_inc,
  output logic              sp_dec
);
  logic ptr_path;  // pointer-based access (indirect or stack)

  always_comb begin
    ram_addr    = addr;
    ram_we      = 1'b0;
    bit_mode    = 1'b0;
    bit_pos     = flag_bit_pos(addr);
    ld_byte     = 1'b0;
    ld_bit      = 1'b0;
    sfr_hit     = 1'b0;
    sfr_bit_hit = 1'b0;
    sp_inc      = 1'b0;
    sp_dec      = 1'b0;
    ptr_path    = 1'b0;
    case (op)
      OP_DIR_RD, OP_DIR_WR: begin
        sfr_hit = in_upper_half(addr);
        ram_we  = (op == OP_DIR_WR) && !in_upper_half(addr);
        ld_byte = (op == OP_DIR_RD);
      end
      OP_IND_RD, OP_IND_WR: begin
        ptr_path = 1'b1;
        ram_we   = (op == OP_IND_WR);
        ld_byte  = (op == OP_IND_RD);
      end
      OP_REG_RD, OP_REG_WR: begin
        ram_addr = reg_byte_addr(bank_sel, addr[REG_W-1:0]);
        ram_we   = (op == OP_REG_WR);
        ld_byte  = (op == OP_REG_RD);
      end
      OP_BIT_RD, OP_BIT_WR: begin
        sfr_hit     = in_upper_half(addr);
        sfr_bit_hit = in_upper_half(addr);
        ram_addr    = flag_byte_addr(addr);
        bit_mode    = 1'b1;
        ram_we      = (op == OP_BIT_WR) && !in_upper_half(addr);
        ld_bit      = (op == OP_BIT_RD);
      end
      OP_PUSH: begin
        ptr_path = 1'b1;
        ram_addr = sp + ADDR_W'(1);
        ram_we   = 1'b1;
        sp_inc   = 1'b1;
      end
      OP_POP: begin
        ptr_path = 1'b1;
        ram_addr = sp;
        ld_byte  = 1'b1;
        sp_dec   = 1'b1;
      end
      default: ;
    endcase
  end

  // Only pointer accesses may write the upper half.
  assert_upper_ptr_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ptr_path) |-> !in_upper_half(ram_addr));

  // A diverted access never writes RAM.
  assert_sfr_no_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_hit |-> !ram_we);

  // Flag writes stay inside the bit window.
  assert_flag_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && bit_mode) |-> (ram_addr >= BIT_WIN_BASE && ram_addr <= BIT_WIN_LAST));
endmodule

// File: rtl/idata_store.sv
module idata_store
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic              ram_we,
  input  logic              bit_mode,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_bit
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] sel_mask;
  logic [DATA_W-1:0] merged;

  assign rd_q   = mem[ram_addr];
  assign rd_bit = rd_q[bit_pos];

  // Per-lane merge: byte writes take wdata, flag writes replace one lane.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign sel_mask[g] = (bit_pos == POS_W'(g));
    assign merged[g]   = bit_mode ? (sel_mask[g] ? wbit : rd_q[g]) : wdata[g];
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= merged;
  end

  // Flag write leaves the other seven bits alone.
  assert_flag_rmw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && bit_mode) |=>
      (((mem[$past(ram_addr)] ^ $past(rd_q)) & ~$past(sel_mask)) == '0));

  // Byte write stores the data word.
  assert_byte_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !bit_mode) |=> (mem[$past(ram_addr)] == $past(wdata)));
endmodule

// File: rtl/idata_sp.sv
module idata_sp
  import idata_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_inc,
  input  logic              sp_dec,
  output logic [ADDR_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= SP_RESET;
    else if (sp_inc) sp <= sp + ADDR_W'(1);
    else if (sp_dec) sp <= sp - ADDR_W'(1);
  end

  assert_push_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_inc |=> (sp == $past(sp) + ADDR_W'(1)));

  assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dec |=> (sp == $past(sp) - ADDR_W'(1)));

  assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_inc && !sp_dec) |=> $stable(sp));
endmodule

// File: rtl/idata_ram.sv
module idata_ram
  import idata_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wbit,
  output logic [DATA_W-1:0] rdata,
  output logic              rbit,
  output logic              sfr_sel,
  output logic              sfr_bit,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [ADDR_W-1:0] sp
);
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_we;
  logic              bit_mode;
  logic [POS_W-1:0]  bit_pos;
  logic              ld_byte;
  logic              ld_bit;
  logic              sfr_hit;
  logic              sfr_bit_hit;
  logic              sp_inc;
  logic              sp_dec;
  logic [DATA_W-1:0] rd_q;
  logic              rd_bit;

  idata_decode u_decode (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .bank_sel(bank_sel), .sp(sp),
    .ram_addr(ram_addr), .ram_we(ram_we), .bit_mode(bit_mode), .bit_pos(bit_pos),
    .ld_byte(ld_byte), .ld_bit(ld_bit), .sfr_hit(sfr_hit), .sfr_bit_hit(sfr_bit_hit),
    .sp_inc(sp_inc), .sp_dec(sp_dec)
  );

  idata_store u_store (
    .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_we(ram_we),
    .bit_mode(bit_mode), .bit_pos(bit_pos), .wdata(wdata), .wbit(wbit),
    .rd_q(rd_q), .rd_bit(rd_bit)
  );

  idata_sp #(.SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .sp_inc(sp_inc), .sp_dec(sp_dec), .sp(sp)
  );

  assign sfr_sel  = sfr_hit;
  assign sfr_bit  = sfr_bit_hit;
  assign sfr_addr = sfr_hit ? addr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rbit  <= 1'b0;
    end else begin
      if (ld_byte) rdata <= sfr_hit ? '0 : rd_q;
      if (ld_bit)  rbit  <= sfr_hit ? 1'b0 : rd_bit;
    end
  end

  // Read results move only on a read opcode.
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_byte |=> $stable(rdata));

  assert_sfr_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_byte && sfr_hit) |=> (rdata == '0));
endmodule

// File: tb/tb_idata_ram.sv
module tb_idata_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] addr = 8'd0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       wbit = 1'b0;
  logic [7:0] rdata;
  logic       rbit;
  logic       sfr_sel;
  logic       sfr_bit;
  logic [7:0] sfr_addr;
  logic [7:0] sp;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  idata_ram dut (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .bank_sel(bank_sel),
    .wdata(wdata), .wbit(wbit), .rdata(rdata), .rbit(rbit), .sfr_sel(sfr_sel),
    .sfr_bit(sfr_bit), .sfr_addr(sfr_addr), .sp(sp)
  );

  // {req, op, addr, bank, wdata, wbit, kind, expect}
  // kind: 0 none, 1 rdata next cycle, 2 rbit next cycle, 3 byte divert now, 4 bit divert now
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, 4'd4,  8'h90, 2'd0, 8'hA5, 1'b0, 3'd0, 8'h00},  // R1 upper write
    {4'd1, 4'd3,  8'h90, 2'd0, 8'h00, 1'b0, 3'd1, 8'hA5},  // R1 upper read
    {4'd2, 4'd2,  8'h30, 2'd0, 8'h3C, 1'b0, 3'd0, 8'h00},  // R2 direct write
    {4'd2, 4'd3,  8'h30, 2'd0, 8'h00, 1'b0, 3'd1, 8'h3C},  // R2 seen indirectly
    {4'd2, 4'd4,  8'h45, 2'd0, 8'h77, 1'b0, 3'd0, 8'h00},  // R2 indirect write
    {4'd2, 4'd1,  8'h45, 2'd0, 8'h00, 1'b0, 3'd1, 8'h77},  // R2 seen directly
    {4'd3, 4'd2,  8'h90, 2'd0, 8'h11, 1'b0, 3'd3, 8'h90},  // R3 diverted write
    {4'd3, 4'd3,  8'h90, 2'd0, 8'h00, 1'b0, 3'd1, 8'hA5},  // R3 upper byte kept
    {4'd3, 4'd1,  8'hA0, 2'd0, 8'h00, 1'b0, 3'd3, 8'hA0},  // R3 diverted read
    {4'd3, 4'd0,  8'h00, 2'd0, 8'h00, 1'b0, 3'd1, 8'h00},  // R3 it loaded zero
    {4'd4, 4'd6,  8'h05, 2'd2, 8'h5A, 1'b0, 3'd0, 8'h00},  // R4 bank2 r5
    {4'd4, 4'd3,  8'h15, 2'd0, 8'h00, 1'b0, 3'd1, 8'h5A},  // R4 at 0x15
    {4'd4, 4'd4,  8'h1F, 2'd0, 8'hC3, 1'b0, 3'd0, 8'h00},  // R4 prime 0x1F
    {4'd4, 4'd5,  8'h07, 2'd3, 8'h00, 1'b0, 3'd1, 8'hC3},  // R4 bank3 r7
    {4'd6, 4'd4,  8'h22, 2'd0, 8'h00, 1'b0, 3'd0, 8'h00},  // R6 clear 0x22
    {4'd6, 4'd8,  8'h13, 2'd0, 8'h00, 1'b1, 3'd0, 8'h00},  // R6 set flag 0x13
    {4'd6, 4'd3,  8'h22, 2'd0, 8'h00, 1'b0, 3'd1, 8'h08},  // R6 only bit 3
    {4'd6, 4'd4,  8'h2F, 2'd0, 8'hFF, 1'b0, 3'd0, 8'h00},  // R6 fill 0x2F
    {4'd6, 4'd8,  8'h7F, 2'd0, 8'h00, 1'b0, 3'd0, 8'h00},  // R6 clear flag 0x7F
    {4'd6, 4'd3,  8'h2F, 2'd0, 8'h00, 1'b0, 3'd1, 8'h7F},  // R6 only bit 7
    {4'd5, 4'd7,  8'h7E, 2'd0, 8'h00, 1'b0, 3'd2, 8'h01},  // R5 flag 0x7E
    {4'd5, 4'd7,  8'h7F, 2'd0, 8'h00, 1'b0, 3'd2, 8'h00},  // R5 flag 0x7F
    {4'd5, 4'd4,  8'h20, 2'd0, 8'h01, 1'b0, 3'd0, 8'h00},  // R5 prime 0x20
    {4'd5, 4'd7,  8'h00, 2'd0, 8'h00, 1'b0, 3'd2, 8'h01},  // R5 flag 0
    {4'd7, 4'd8,  8'h85, 2'd0, 8'h00, 1'b0, 3'd4, 8'h85},  // R7 diverted flag write
    {4'd7, 4'd3,  8'h30, 2'd0, 8'h00, 1'b0, 3'd1, 8'h3C},  // R7 0x30 untouched
    {4'd7, 4'd7,  8'h85, 2'd0, 8'h00, 1'b0, 3'd4, 8'h85},  // R7 diverted flag read
    {4'd7, 4'd0,  8'h00, 2'd0, 8'h00, 1'b0, 3'd2, 8'h00}   // R7 it loaded zero
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [1:0] b,
                      input logic [7:0] d, input logic w);
    op = o; addr = a; bank_sel = b; wdata = d; wbit = w;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(9, sp, 8'h07);
    chk(9, rdata, 8'h00);
    chk(9, {7'd0, rbit}, 8'h00);
    chk(9, {7'd0, sfr_sel}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] req, vo, kind_unused;
      logic [7:0] va, vd, ve;
      logic [1:0] vb;
      logic       vw;
      logic [2:0] kind;
      {req, vo, va, vb, vd, vw, kind, ve} = VEC[i];
      kind_unused = 4'd0;
      op = vo; addr = va; bank_sel = vb; wdata = vd; wbit = vw;
      #1;
      if (kind == 3'd3 || kind == 3'd4) begin
        chk(int'(req), {7'd0, sfr_sel}, 8'h01);
        chk(int'(req), {7'd0, sfr_bit}, (kind == 3'd4) ? 8'h01 : 8'h00);
        chk(int'(req), sfr_addr, ve);
      end
      @(negedge clk);
      if (kind == 3'd1) chk(int'(req), rdata, ve);
      if (kind == 3'd2) chk(int'(req), {7'd0, rbit}, ve);
    end

    // R8 push and pop
    step(4'd9, 8'h00, 2'd0, 8'h11, 1'b0);
    chk(8, sp, 8'h08);
    step(4'd9, 8'h00, 2'd0, 8'h22, 1'b0);
    chk(8, sp, 8'h09);
    step(4'd3, 8'h08, 2'd0, 8'h00, 1'b0);
    chk(8, rdata, 8'h11);
    step(4'd10, 8'h00, 2'd0, 8'h00, 1'b0);
    chk(8, rdata, 8'h22);
    chk(8, sp, 8'h08);
    step(4'd10, 8'h00, 2'd0, 8'h00, 1'b0);
    chk(8, rdata, 8'h11);
    chk(8, sp, 8'h07);

    // R10 undefined opcode behaves as idle
    step(4'd4, 8'h50, 2'd0, 8'h99, 1'b0);
    step(4'd3, 8'h50, 2'd0, 8'h00, 1'b0);
    chk(10, rdata, 8'h99);
    step(4'd15, 8'h50, 2'd0, 8'h00, 1'b1);
    chk(10, rdata, 8'h99);
    chk(10, sp, 8'h07);
    chk(10, {7'd0, rbit}, 8'h00);
    step(4'd3, 8'h50, 2'd0, 8'h00, 1'b0);
    chk(10, rdata, 8'h99);
    step(4'd0, 8'hF0, 2'd0, 8'h00, 1'b0);
    chk(10, rdata, 8'h99);
    chk(10, {7'd0, sfr_sel}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule